// File: doc/BRIEF.md
# Dual-Clock FIFO with Reflected Gray Pointers

This block carries fixed-width data words from a producer clocked by one clock to a consumer clocked by an unrelated clock. The producer pushes a word whenever it asserts its write enable while the full flag is low. The consumer sees the oldest stored word on its data output whenever the empty flag is low, and it removes that word by asserting its read enable.

Each side keeps its position in a ring of twice the storage depth. That position is turned into a Gray-coded value and passed through a two-stage flop chain into the other clock domain. The depth is a parameter and need not be a power of two. In that case the ring does not start at Gray value zero. It occupies a window of binary counts centred on the midpoint of the Gray code space. Because the Gray code is mirrored about that midpoint, the last count of the window and the first count differ only in the top bit. Every pointer step therefore changes a single bit, including the step that wraps around.

The read side raises empty when its own Gray pointer equals the write pointer that has crossed over. The write side converts the read pointer that has crossed over back to a ring index and raises full when exactly `DEPTH` words are outstanding.

Top module: `gray_fifo`

## Requirements
- R1: Words leave on `rd_data` in the order they were accepted, with none lost or duplicated.
- R2: Each Gray pointer changes by at most one bit per clock of its domain, also when it wraps from the last ring position to the first. It changes only when an accepted operation occurs. This keeps data correct through repeated wraps.
- R3: The pointer ring has 2×`DEPTH` positions. These map to binary counts starting at BASE = (2^PW − 2×`DEPTH`)/2, where PW is the smallest width with 2^PW ≥ 2×`DEPTH`.
- R4: `rd_empty` is high whenever every accepted word has been read and the write pointer has crossed over.
- R5: `wr_full` goes high on the write clock edge that accepts the `DEPTH`-th outstanding word. It goes low a few write clocks after a read frees a slot.
- R6: A write request while `wr_full` is high is ignored. No word is stored and the pointer does not move.
- R7: A read request while `rd_empty` is high is ignored. The read pointer does not move, and the next word written is the next word read.
- R8: After a word is written into an empty FIFO, `rd_empty` falls within 4 read clock edges.
- R9: While reset is applied and right after it, `wr_full` is 0 and `rd_empty` is 1. Both resets are synchronous and active high.
- R10: While `rd_empty` is low, `rd_data` shows the oldest unread word without needing a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| wr_full | output | 1 | No free slot; write requests ignored |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Read request, pops the word on rd_data |
| rd_data | output | WIDTH | Oldest unread word (show-ahead) |
| rd_empty | output | 1 | No unread word; read requests ignored |

## Verification
On every clock, the assertions check that each Gray pointer moves by at most one bit, including across the wrap. They also check that a pointer holds still when there is no request, when a write meets full, and when a read meets empty. Some behaviour shows only across whole scenarios: ordering and loss-free delivery against a reference queue, the exact point at which full appears, the bound on the latency before empty falls, and that a refused write leaves no trace in the data. The bench's scenarios cover these under two unrelated clocks and repeated wraps of a depth-6 ring.

// File: rtl/gfifo_pkg.sv
package gfifo_pkg;

    // Smallest width whose code space holds 2*depth ring positions.
    function automatic int ptr_bits(input int depth);
        int w;
        w = 1;
        while ((1 << w) < 2 * depth) w++;
        return w;
    endfunction

    // First binary count of the ring, centred on the Gray mirror axis.
    function automatic int ptr_base(input int depth);
        return ((1 << ptr_bits(depth)) - 2 * depth) / 2;
    endfunction

endpackage

// File: rtl/gfifo_g2b.sv
module gfifo_g2b #(
    parameter int W = 4
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/gfifo_sync.sv
module gfifo_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gfifo_ptr.sv
module gfifo_ptr #(
    parameter int DEPTH = 6,
    localparam int PW   = gfifo_pkg::ptr_bits(DEPTH),
    localparam int BASE = gfifo_pkg::ptr_base(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [PW-1:0] idx,
    output logic [PW-1:0] gray
);
    localparam logic [PW-1:0] LAST  = PW'(2 * DEPTH - 1);
    localparam logic [PW-1:0] BASEV = PW'(BASE);
    localparam logic [PW-1:0] GBASE = BASEV ^ (BASEV >> 1);

    logic [PW-1:0] idx_nxt;
    logic [PW-1:0] seq_nxt;

    always_comb begin
        idx_nxt = (idx == LAST) ? '0 : idx + 1'b1;
        seq_nxt = idx_nxt + BASEV;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            gray <= GBASE;
        end else if (step) begin
            idx  <= idx_nxt;
            gray <= seq_nxt ^ (seq_nxt >> 1);
        end
    end
endmodule

// File: rtl/gfifo_mem.sv
module gfifo_mem #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 8,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/gray_fifo.sv
module gray_fifo #(
    parameter int DEPTH = 6,
    parameter int WIDTH = 8
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_full,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_empty
);
    localparam int PW   = gfifo_pkg::ptr_bits(DEPTH);
    localparam int BASE = gfifo_pkg::ptr_base(DEPTH);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] BASEV = PW'(BASE);
    localparam logic [PW-1:0] GBASE = BASEV ^ (BASEV >> 1);
    localparam logic [PW:0]   RING  = (PW+1)'(2 * DEPTH);
    localparam logic [PW:0]   FULLN = (PW+1)'(DEPTH);

    logic [PW-1:0] wr_idx, wr_gray, rd_idx, rd_gray;
    logic [PW-1:0] rgray_w, wgray_r, rbin_w, ridx_w;
    logic [PW:0]   occ_raw, occ;
    logic [AW-1:0] waddr, raddr;
    logic          wr_step, rd_step;

    assign wr_step = wr_en & ~wr_full;
    assign rd_step = rd_en & ~rd_empty;

    gfifo_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk(wr_clk), .rst(wr_rst), .step(wr_step), .idx(wr_idx), .gray(wr_gray)
    );
    gfifo_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk(rd_clk), .rst(rd_rst), .step(rd_step), .idx(rd_idx), .gray(rd_gray)
    );

    gfifo_sync #(.W(PW), .RST_VAL(GBASE)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rd_gray), .q(rgray_w)
    );
    gfifo_sync #(.W(PW), .RST_VAL(GBASE)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wr_gray), .q(wgray_r)
    );

    // Write side: rebuild the read ring index and count outstanding words.
    gfifo_g2b #(.W(PW)) u_rconv (.gray(rgray_w), .bin(rbin_w));

    always_comb begin
        ridx_w  = rbin_w - BASEV;
        occ_raw = {1'b0, wr_idx} + RING - {1'b0, ridx_w};
        occ     = (occ_raw >= RING) ? occ_raw - RING : occ_raw;
    end

    assign wr_full  = (occ == FULLN);
    assign rd_empty = (rd_gray == wgray_r);

    always_comb begin
        waddr = (wr_idx >= PW'(DEPTH)) ? AW'(wr_idx - PW'(DEPTH)) : AW'(wr_idx);
        raddr = (rd_idx >= PW'(DEPTH)) ? AW'(rd_idx - PW'(DEPTH)) : AW'(rd_idx);
    end

    gfifo_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_mem (
        .clk(wr_clk), .we(wr_step), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(rd_data)
    );
endmodule

// File: rtl/gray_fifo_chk.sv
module gray_fifo_chk #(
    parameter int PW = 4
) (
    input logic          wr_clk,
    input logic          wr_rst,
    input logic          wr_en,
    input logic          wr_full,
    input logic [PW-1:0] wr_gray,
    input logic          rd_clk,
    input logic          rd_rst,
    input logic          rd_en,
    input logic          rd_empty,
    input logic [PW-1:0] rd_gray
);
    // R2
    wr_one_bit_step_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R2
    rd_one_bit_step_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    // R2
    wr_idle_hold_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        !wr_en |=> $stable(wr_gray));

    // R6
    write_when_full_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> $stable(wr_gray));

    // R7
    read_when_empty_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> $stable(rd_gray));
endmodule

bind gray_fifo gray_fifo_chk #(.PW(PW)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_full(wr_full),
    .wr_gray(wr_gray), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_empty(rd_empty), .rd_gray(rd_gray)
);

// File: tb/gray_fifo_tb.sv
`timescale 1ns/1ps
module gray_fifo_tb;
    localparam int DEPTH = 6;
    localparam int WIDTH = 8;

    // Each row: words to push, then words to pop. Occupancy never exceeds DEPTH.
    localparam int NVEC = 7;
    localparam int VEC [NVEC][2] = '{
        '{3, 2}, '{4, 5}, '{6, 0}, '{0, 6}, '{1, 1}, '{5, 4}, '{0, 1}
    };

    logic             wr_clk = 1'b0, rd_clk = 1'b0;
    logic             wr_rst = 1'b1, rd_rst = 1'b1;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic             wr_full, rd_empty;

    int checks = 0;
    int errors = 0;
    logic [WIDTH-1:0] refq [$];
    logic [WIDTH-1:0] seed = 8'h11;

    always #2.5  wr_clk = ~wr_clk;
    always #3.65 rd_clk = ~rd_clk;

    gray_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_data(rd_data), .rd_empty(rd_empty)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Caller is at a write-clock falling edge.
    task automatic push(input logic [WIDTH-1:0] d);
        while (wr_full) @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
        refq.push_back(d);
    endtask

    // Caller is at a read-clock falling edge; checks show-ahead data first.
    task automatic pop(input string tag);
        logic [WIDTH-1:0] exp;
        while (rd_empty) @(negedge rd_clk);
        exp = (refq.size() > 0) ? refq.pop_front() : '0;
        check(rd_data == exp, tag, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [WIDTH-1:0] next_word();
        seed = {seed[6:0], seed[7] ^ seed[5] ^ seed[4] ^ seed[3]};
        return seed;
    endfunction

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        int n;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        // R9: flags during reset
        check(wr_full == 1'b0, "R9 full in reset", int'(wr_full), 0);
        check(rd_empty == 1'b1, "R9 empty in reset", int'(rd_empty), 1);
        @(negedge wr_clk) wr_rst = 1'b0;
        @(negedge rd_clk) rd_rst = 1'b0;
        repeat (3) @(negedge rd_clk);
        check(wr_full == 1'b0 && rd_empty == 1'b1, "R9 flags after reset",
              int'({wr_full, rd_empty}), 1);

        // R1 R10: table of push/pop bursts
        for (int v = 0; v < NVEC; v++) begin
            @(negedge wr_clk);
            for (int k = 0; k < VEC[v][0]; k++) push(next_word());
            @(negedge rd_clk);
            for (int k = 0; k < VEC[v][1]; k++) pop("R1 R10 table order");
        end
        repeat (6) @(negedge rd_clk);
        check(rd_empty == 1'b1, "R4 empty after table", int'(rd_empty), 1);

        // R8: empty falls within 4 read edges of a write
        @(negedge wr_clk);
        push(8'h3C);
        n = 0;
        while (rd_empty && n < 10) begin
            @(negedge rd_clk);
            n++;
        end
        check(n <= 4 && !rd_empty, "R8 empty latency", n, 4);
        @(negedge rd_clk);
        pop("R1 latency word");

        // R5: fill to DEPTH
        @(negedge wr_clk);
        for (int k = 0; k < DEPTH - 1; k++) begin
            push(next_word());
            check(wr_full == 1'b0, "R5 not full early", int'(wr_full), 0);
        end
        push(next_word());
        check(wr_full == 1'b1, "R5 full at DEPTH", int'(wr_full), 1);

        // R5: full drops after a read, then refill
        @(negedge rd_clk);
        pop("R1 pop from full");
        repeat (8) @(negedge wr_clk);
        check(wr_full == 1'b0, "R5 full released", int'(wr_full), 0);
        push(8'hC3);
        check(wr_full == 1'b1, "R5 full again", int'(wr_full), 1);

        // R6: writes while full are dropped
        wr_en = 1'b1;
        wr_data = 8'hEE;
        repeat (3) @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_full == 1'b1, "R6 still full", int'(wr_full), 1);
        @(negedge rd_clk);
        for (int k = 0; k < DEPTH; k++) pop("R6 drain without dropped word");
        repeat (8) @(negedge rd_clk);
        check(rd_empty == 1'b1, "R6 no extra word stored", int'(rd_empty), 1);

        // R7: reads while empty are ignored
        rd_en = 1'b1;
        repeat (3) @(negedge rd_clk);
        rd_en = 1'b0;
        repeat (4) @(negedge rd_clk);
        check(rd_empty == 1'b1, "R7 empty held", int'(rd_empty), 1);
        @(negedge wr_clk);
        push(8'h5A);
        @(negedge rd_clk);
        pop("R7 next word after ignored reads");

        // R2 R3: concurrent streaming across several ring wraps
        fork
            begin
                @(negedge wr_clk);
                for (int k = 0; k < 8 * DEPTH; k++) push(next_word());
            end
            begin
                @(negedge rd_clk);
                for (int k = 0; k < 8 * DEPTH; k++) pop("R2 R3 stream through wraps");
            end
        join
        repeat (8) @(negedge rd_clk);
        check(rd_empty == 1'b1 && refq.size() == 0, "R4 empty after stream",
              int'(rd_empty), 1);
        finish_run();
    end
endmodule